// File: doc/BRIEF.md
# Timer Update to DAC Trigger Router

This block collects the update-event strobes from one master timer and a parameterised set of timer units. It steers each of them onto one of three DAC trigger lines. Every source has a private two-bit steering field. A field either mutes its source or names the trigger line the source feeds. Software, or a neighbouring controller, sets the fields through a small synchronous write port and reads them back on a registered read port.

The update inputs are level strobes. A source contributes an event only in the cycle where its strobe rises. All rising sources steered to the same line are ORed together. Each line then passes through a registered pulse shaper. The shaper guarantees that a line is never high in two consecutive clock cycles. If an event arrives while its line is already pulsing, the event is held back by one cycle instead of stretching the pulse. A new steering value applies from the cycle after the write. An event that coincides with the write is routed by the previous value.

Top module: `dac_trig_router`

## Requirements
- R1: While reset is high, at the next clock edge `dac_trig_o` and `cfg_rdata_o` become 0 and every steering field returns to code 00.
- R2: A source whose steering field holds 00 causes no pulse on any trigger line.
- R3: Code 01 steers a source to `dac_trig_o[0]`, code 10 steers it to `dac_trig_o[1]` and code 11 steers it to `dac_trig_o[2]`.
- R4: Sources steered to the same line that rise in the same cycle produce a single one-cycle pulse on that line.
- R5: A strobe held high for several cycles produces exactly one pulse, because only its rising edge counts.
- R6: No trigger line is ever high in two consecutive cycles. An event that arrives while its line is high is emitted one cycle later.
- R7: A rising strobe that finds its line idle raises that line at the first clock edge at which the strobe is sampled high, for exactly one cycle.
- R8: A write to a steering field takes effect from the following cycle. An event sampled at the same edge as the write uses the old code.
- R9: Field address 0 is the master timer and address i+1 is timer unit i. `cfg_rdata_o` returns, one clock after `cfg_raddr_i` is sampled, the field value held before that edge.
- R10: A write to an address at or above the number of sources changes nothing, and a read of such an address returns 00.
- R11: Each source keeps its own field, and a write to one address leaves every other field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_master_i | input | 1 | Master timer update strobe (level) |
| upd_unit_i | input | NUM_UNITS | Timer unit update strobes, bit i is unit i |
| cfg_we_i | input | 1 | Steering field write enable |
| cfg_waddr_i | input | $clog2(NUM_UNITS+1) | Field write address |
| cfg_wdata_i | input | 2 | Steering code to write |
| cfg_raddr_i | input | $clog2(NUM_UNITS+1) | Field read address |
| cfg_rdata_o | output | 2 | Registered read data |
| dac_trig_o | output | 3 | Trigger pulses, bit k is trigger line k+1 |

## Verification
The assertions check on every cycle that no trigger line stays high for two cycles, that a deferred event is always emitted on the next cycle, and that every pulse has a rising strobe or a pending event behind it. They also check that a single strobe's detected edge lasts one cycle, that a field write lands while other fields hold, and that out-of-range reads give 00. Only the bench's scenarios can show that the codes reach the right line, that a write coinciding with an event uses the old code, and that held strobes or merged sources give the expected pulse counts. They also show the one-cycle deferral when events arrive back to back on one line, because these depend on sequences of stimulus compared against an independent model.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int NUM_TRIG = 3;
  localparam int CODE_W   = 2;

  typedef enum logic [CODE_W-1:0] {
    STEER_OFF   = 2'b00,
    STEER_TRIG1 = 2'b01,
    STEER_TRIG2 = 2'b10,
    STEER_TRIG3 = 2'b11
  } steer_e;

  // One-hot line select for a steering code; zero for the mute code.
  function automatic logic [NUM_TRIG-1:0] steer_onehot(input logic [CODE_W-1:0] code);
    logic [NUM_TRIG-1:0] sel;
    sel = '0;
    case (steer_e'(code))
      STEER_TRIG1: sel[0] = 1'b1;
      STEER_TRIG2: sel[1] = 1'b1;
      STEER_TRIG3: sel[2] = 1'b1;
      default:     sel    = '0;
    endcase
    return sel;
  endfunction

  // Shaper next state: a request fires when the line is idle, else it waits.
  function automatic logic [1:0] shape_next(input logic req, input logic busy);
    return {req & busy, req & ~busy};  // {pending, pulse}
  endfunction
endpackage

// File: rtl/dtr_steer_bank.sv
module dtr_steer_bank
  import dtr_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [CODE_W-1:0]           wdata_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [CODE_W-1:0]           rdata_o,
  output logic [NUM_SRC*CODE_W-1:0]   steer_o
);
  logic [NUM_SRC-1:0]      wsel;
  logic [CODE_W-1:0]       field_q [NUM_SRC];
  logic [CODE_W-1:0]       rd_mux;
  logic [CODE_W-1:0]       rd_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    assign wsel[s] = we_i && (int'(waddr_i) == s);

    always_ff @(posedge clk) begin
      if (rst)          field_q[s] <= STEER_OFF;
      else if (wsel[s]) field_q[s] <= wdata_i;
    end

    assign steer_o[s*CODE_W +: CODE_W] = field_q[s];

    // A selected write lands in the field on the next cycle.
    p_field_write_r8: assert property (@(posedge clk) disable iff (rst)
      wsel[s] |=> (field_q[s] == $past(wdata_i)));

    // Fields not addressed keep their value.
    p_field_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !wsel[s] |=> $stable(field_q[s]));
  end

  always_comb begin
    rd_mux = STEER_OFF;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (int'(raddr_i) == s) rd_mux = field_q[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rdata_o = rd_q;

  p_bad_read_r10: assert property (@(posedge clk) disable iff (rst)
    (int'(raddr_i) >= NUM_SRC) |=> (rdata_o == '0));
endmodule

// File: rtl/dtr_rise_detect.sv
module dtr_rise_detect #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] upd_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= upd_i;
  end

  assign rise_o = upd_i & ~prev_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    // A held strobe yields its event in one cycle only.
    p_rise_once_r5: assert property (@(posedge clk) disable iff (rst)
      rise_o[s] |=> !rise_o[s]);
  end
endmodule

// File: rtl/dtr_route_merge.sv
module dtr_route_merge
  import dtr_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0]        rise_i,
  input  logic [NUM_SRC*CODE_W-1:0] steer_i,
  output logic [NUM_TRIG-1:0]       hit_o
);
  logic [NUM_TRIG-1:0] contrib [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign contrib[s] = steer_onehot(steer_i[s*CODE_W +: CODE_W]) & {NUM_TRIG{rise_i[s]}};
  end

  always_comb begin
    hit_o = '0;
    for (int s = 0; s < NUM_SRC; s++) hit_o = hit_o | contrib[s];
  end

  // Without any rising strobe no line may be requested.
  always_comb begin
    if (rise_i == '0) p_quiet_r2: assert (hit_o == '0);
  end
endmodule

// File: rtl/dtr_pulse_shaper.sv
module dtr_pulse_shaper
  import dtr_pkg::*;
#(
  parameter int LINES = NUM_TRIG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] hit_i,
  output logic [LINES-1:0] trig_o,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] trig_q, pend_q;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic [1:0] nxt;
    assign nxt = shape_next(hit_i[k] | pend_q[k], trig_q[k]);

    always_ff @(posedge clk) begin
      if (rst) begin
        trig_q[k] <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        trig_q[k] <= nxt[0];
        pend_q[k] <= nxt[1];
      end
    end

    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
      trig_q[k] |=> !trig_q[k]);

    p_deferred_r6: assert property (@(posedge clk) disable iff (rst)
      pend_q[k] |=> trig_q[k]);

    p_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(trig_q[k]) |-> $past(hit_i[k] | pend_q[k]));
  end

  assign trig_o = trig_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dac_trig_router.sv
module dac_trig_router
  import dtr_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  localparam int NUM_SRC  = NUM_UNITS + 1,
  localparam int ADDR_W   = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_master_i,
  input  logic [NUM_UNITS-1:0] upd_unit_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_waddr_i,
  input  logic [1:0]           cfg_wdata_i,
  input  logic [ADDR_W-1:0]    cfg_raddr_i,
  output logic [1:0]           cfg_rdata_o,
  output logic [2:0]           dac_trig_o
);
  logic [NUM_SRC-1:0]        upd_all;
  logic [NUM_SRC-1:0]        rise;
  logic [NUM_SRC*CODE_W-1:0] steer;
  logic [NUM_TRIG-1:0]       hit;
  logic [NUM_TRIG-1:0]       pend;

  assign upd_all = {upd_unit_i, upd_master_i};

  dtr_steer_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst),
    .we_i(cfg_we_i), .waddr_i(cfg_waddr_i), .wdata_i(cfg_wdata_i),
    .raddr_i(cfg_raddr_i), .rdata_o(cfg_rdata_o), .steer_o(steer)
  );

  dtr_rise_detect #(.NUM_SRC(NUM_SRC)) u_rise (
    .clk(clk), .rst(rst), .upd_i(upd_all), .rise_o(rise)
  );

  dtr_route_merge #(.NUM_SRC(NUM_SRC)) u_route (
    .rise_i(rise), .steer_i(steer), .hit_o(hit)
  );

  dtr_pulse_shaper #(.LINES(NUM_TRIG)) u_shape (
    .clk(clk), .rst(rst), .hit_i(hit), .trig_o(dac_trig_o), .pend_o(pend)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (dac_trig_o == '0 && cfg_rdata_o == '0 && pend == '0));
endmodule

// File: tb/dac_trig_router_test.sv
`timescale 1ns/1ps
module dac_trig_router_test;
  localparam int NUM_UNITS = 5;
  localparam int NUM_SRC   = NUM_UNITS + 1;
  localparam int AW        = $clog2(NUM_SRC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_master_i = 1'b0;
  logic [NUM_UNITS-1:0] upd_unit_i = '0;
  logic cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_waddr_i = '0;
  logic [1:0] cfg_wdata_i = '0;
  logic [AW-1:0] cfg_raddr_i = '0;
  logic [1:0] cfg_rdata_o;
  logic [2:0] dac_trig_o;

  always #2.5 clk = ~clk;

  dac_trig_router #(.NUM_UNITS(NUM_UNITS)) uut (
    .clk(clk), .rst(rst), .upd_master_i(upd_master_i), .upd_unit_i(upd_unit_i),
    .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_waddr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_raddr_i(cfg_raddr_i), .cfg_rdata_o(cfg_rdata_o), .dac_trig_o(dac_trig_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Scoreboard queues, one entry per driven cycle.
  logic [2:0] q_trig[$];
  logic [1:0] q_rd[$];
  string      q_tag[$];

  // Bench model state, written from the requirements.
  logic [1:0] m_code [NUM_SRC];
  logic [NUM_SRC-1:0] m_prev = '0;
  logic [2:0] m_out = '0;
  logic [2:0] m_wait = '0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NUM_SRC-1:0] u, input logic we, input int wa,
                      input logic [1:0] wd, input int ra, input string tag);
    logic [2:0] fresh, nout, nwait;
    logic [1:0] rd;
    @(negedge clk);
    upd_master_i = u[0];
    upd_unit_i   = u[NUM_SRC-1:1];
    cfg_we_i     = we;
    cfg_waddr_i  = wa[AW-1:0];
    cfg_wdata_i  = wd;
    cfg_raddr_i  = ra[AW-1:0];
    fresh = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (u[s] && !m_prev[s] && m_code[s] != 2'b00) fresh[m_code[s] - 1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      nout[k]  = (fresh[k] || m_wait[k]) && !m_out[k];
      nwait[k] = (fresh[k] || m_wait[k]) && m_out[k];
    end
    rd = (ra < NUM_SRC) ? m_code[ra] : 2'b00;
    m_prev = u; m_out = nout; m_wait = nwait;
    if (we && wa < NUM_SRC) m_code[wa] = wd;
    q_trig.push_back(nout);
    q_rd.push_back(rd);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, 0, 2'b00, 0, tag);
  endtask

  // Monitor: compares each cycle's outputs with the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_trig.size() > 0) begin
        logic [2:0] et;
        logic [1:0] er;
        string tg;
        et = q_trig.pop_front();
        er = q_rd.pop_front();
        tg = q_tag.pop_front();
        check(tg, "dac_trig_o", int'(dac_trig_o), int'(et));
        check(tg, "cfg_rdata_o", int'(cfg_rdata_o), int'(er));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NUM_SRC; s++) m_code[s] = 2'b00;
    upd_master_i = 1'b1;  // R1: strobe active during reset must not leak out
    repeat (3) @(negedge clk);
    check("R1", "reset dac_trig_o", int'(dac_trig_o), 0);
    check("R1", "reset cfg_rdata_o", int'(cfg_rdata_o), 0);
    upd_master_i = 1'b0;
    rst = 1'b0;

    // R2: all fields at 00 after reset, every source fires
    step('1, 0, 0, 0, 0, "R2");
    step('1, 0, 0, 0, 1, "R2");
    idle(2, "R2");

    // R9/R11: program fields and read them back
    step('0, 1, 0, 2'b01, 0, "R9");
    step('0, 1, 1, 2'b10, 0, "R9");
    step('0, 1, 2, 2'b11, 1, "R11");
    step('0, 0, 0, 0, 2, "R11");
    step('0, 0, 0, 0, 3, "R11");

    // R3/R7: each code to its line
    step(6'b000001, 0, 0, 0, 0, "R3");
    step(6'b000001, 0, 0, 0, 0, "R7");
    step(6'b000010, 0, 0, 0, 0, "R3");
    idle(1, "R3");
    step(6'b000100, 0, 0, 0, 0, "R3");
    idle(1, "R3");

    // R5: held strobe gives one pulse
    for (int i = 0; i < 4; i++) step(6'b000010, 0, 0, 0, 0, "R5");
    idle(1, "R5");

    // R8: write coinciding with the event uses the old code
    step(6'b001000, 1, 3, 2'b01, 3, "R8");
    step(6'b000000, 0, 0, 0, 3, "R8");
    step(6'b001000, 0, 0, 0, 0, "R8");
    idle(1, "R8");

    // R4: two sources on line 1 in the same cycle
    step(6'b001001, 0, 0, 0, 0, "R4");
    idle(2, "R4");

    // R6: back-to-back events on line 1 are spaced by a gap cycle
    step(6'b000001, 0, 0, 0, 0, "R6");
    step(6'b001001, 0, 0, 0, 0, "R6");
    step(6'b001001, 0, 0, 0, 0, "R6");
    idle(2, "R6");

    // R10: out-of-range address has no effect
    step('0, 1, NUM_SRC, 2'b11, NUM_SRC, "R10");
    step('0, 0, 0, 0, NUM_SRC, "R10");
    for (int a = 0; a < NUM_SRC; a++) step('0, 0, 0, 0, a, "R10");
    step(6'b010000, 0, 0, 0, 0, "R10");
    idle(1, "R10");

    // R2: clear a field back to 00 and fire its source
    step('0, 1, 0, 2'b00, 0, "R2");
    step(6'b000001, 0, 0, 0, 0, "R2");
    idle(2, "R2");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule